// File: doc/BRIEF.md
# GPIO Event Detector

This block watches the eight pins of a general-purpose I/O port and turns selected pin activity into a sticky pending flag per pin. It also drives one shared notification line toward a wake or interrupt controller. Each pin has its own three configuration bits:
- whether its active sense is inverted;
- whether the pin passes through a stability filter first;
- whether a rising transition or a steady active level counts as the event.

These bits come straight from configuration register outputs.

Software reaches two runtime registers through a plain register port. The first is an enable mask. The second is the pending flags, which clear when a one is written to them. A pending pin asserts the notification line only while its enable bit is set. The pin inputs are assumed to be already synchronous to `clk`.

Top module: `gpio_evt_notify`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending flags, the enable mask and `evt_notify` all become 0.
- R2: With `cfg_invert[i]`=1, a low pin is the active state and a high pin is inactive. With 0, high is active.
- R3: In level mode (`cfg_edge[i]`=0, no filter), an active pin sets pending bit i at the first clock edge that samples it. If the pin is still active when a clear is written, the bit stays set.
- R4: In edge mode (`cfg_edge[i]`=1), only an inactive-to-active transition sets the bit. An active level that is held after a clear does not set it again.
- R5: With `cfg_debounce[i]`=1, a change of the active state is accepted only after 16 consecutive samples at the new value. The pending bit then sets one edge later. A run of 15 samples has no effect.
- R6: Writing `reg_addr`=1 clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R7: When a trigger and a clear of the same bit meet at one edge, the bit ends up set.
- R8: Writing `reg_addr`=0 loads the enable mask, which reads back at `reg_addr`=0. `evt_notify` is 1 exactly when some bit is both pending and enabled.
- R9: In edge mode, a pin that is already active when reset is released does not set its bit.
- R10: A pending bit stays set after its trigger goes away, until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 8 | Pin levels, synchronous to clk |
| cfg_edge | input | 8 | Per pin: 1 = rising-transition trigger, 0 = level trigger |
| cfg_invert | input | 8 | Per pin: 1 = active low |
| cfg_debounce | input | 8 | Per pin: 1 = pass through the stability filter |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable mask, 1 = pending flags (read and write) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| evt_notify | output | 1 | OR of all pending and enabled bits |

## Verification
The hardest cases to reach are the exact limit of the stability filter and a clear that lands on the same edge as a trigger. A random pin rarely stays put for 15 or 16 samples, and it rarely rises on the very cycle of a write. Directed sequences therefore hold a filtered pin for exactly 15 and then 16 samples, and drive a rising pin and a clear on the same cycle. Random traffic with a low toggle rate then mixes configuration changes, writes and pin activity, and is compared against a cycle model in the bench.

// File: rtl/gpio_evt_pkg.sv
// Shared definitions for the GPIO event detector.
package gpio_evt_pkg;
    // Runtime register selector on the register port.
    typedef enum logic {
        REG_ENABLE  = 1'b0,
        REG_PENDING = 1'b1
    } evt_reg_e;
endpackage

// File: rtl/gpio_evt_debounce.sv
// Stability filter for one pin.
// The output takes a new value only after the input has differed from it
// on STABLE_CYCLES consecutive samples. Reset loads the current input,
// so nothing is filtered right after reset. Assumes raw is synchronous.
module gpio_evt_debounce #(
    parameter int unsigned STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int unsigned CW = $clog2(STABLE_CYCLES) + 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] run_q;

    // Count samples that differ from the output; accept on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt  <= raw;
            run_q <= '0;
        end else if (raw == filt) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            filt  <= raw;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // The output may only move after a full run of differing samples.
    assert_accept_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (filt != $past(filt))) |-> ($past(run_q) == LAST && filt == $past(raw)));
endmodule

// File: rtl/gpio_evt_slice.sv
// Event detection for one pin.
// Applies the polarity, optionally filters, picks the edge or level
// trigger, and holds a sticky pending flag that is cleared by clr.
// A trigger wins over a clear on the same edge. Reset seeds the edge
// history with the selected input, so that no false edge is seen.
module gpio_evt_slice #(
    parameter int unsigned STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic cfg_edge,
    input  logic cfg_invert,
    input  logic cfg_debounce,
    input  logic clr,
    output logic pending
);
    logic active;
    logic filt;
    logic sel;
    logic prev_q;
    logic trig;

    // Polarity: active state becomes logic 1.
    assign active = pin ^ cfg_invert;

    gpio_evt_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_dbnc (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (active),
        .filt (filt)
    );

    // Filter bypass select and trigger type select.
    assign sel  = cfg_debounce ? filt : active;
    assign trig = cfg_edge ? (sel & ~prev_q) : sel;

    // Edge history follows the selected input, seeded at reset.
    always_ff @(posedge clk) begin
        prev_q <= sel;
    end

    // Sticky pending flag: set by trigger, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~clr) | trig;
    end

    assert_trigger_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pending);
    assert_trigger_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && clr) |=> pending);
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !trig) |=> !pending);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr) |=> pending);
    assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_edge) && $rose(pending)) |-> $past(sel && !prev_q));
endmodule

// File: rtl/gpio_evt_notify.sv
// GPIO event detector top.
// Holds one detection slice per pin, the enable mask register and the
// read mux, and ORs the enabled pending flags into one notification line.
// Assumes the pins and the register port are synchronous to clk.
module gpio_evt_notify
    import gpio_evt_pkg::*;
#(
    parameter int unsigned NPINS         = 8,
    parameter int unsigned STABLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] cfg_edge,
    input  logic [NPINS-1:0] cfg_invert,
    input  logic [NPINS-1:0] cfg_debounce,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [NPINS-1:0] reg_wdata,
    output logic [NPINS-1:0] reg_rdata,
    output logic             evt_notify
);
    evt_reg_e         reg_sel;
    logic [NPINS-1:0] enable_q;
    logic [NPINS-1:0] pending;
    logic [NPINS-1:0] clr_vec;

    assign reg_sel = evt_reg_e'(reg_addr);

    // Write-one-to-clear strobes for the pending flags.
    assign clr_vec = (reg_wr && reg_sel == REG_PENDING) ? reg_wdata : '0;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_evt_slice #(.STABLE_CYCLES(STABLE_CYCLES)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin         (pin_in[i]),
            .cfg_edge    (cfg_edge[i]),
            .cfg_invert  (cfg_invert[i]),
            .cfg_debounce(cfg_debounce[i]),
            .clr         (clr_vec[i]),
            .pending     (pending[i])
        );
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               enable_q <= '0;
        else if (reg_wr && reg_sel == REG_ENABLE) enable_q <= reg_wdata;
    end

    // Read mux and notification combine.
    assign reg_rdata  = (reg_sel == REG_ENABLE) ? enable_q : pending;
    assign evt_notify = |(pending & enable_q);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (enable_q == '0 && pending == '0 && !evt_notify));
    assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == REG_ENABLE) |=> (enable_q == $past(reg_wdata)));
    assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(reg_wr && reg_sel == REG_ENABLE)) |=> $stable(enable_q));
endmodule

// File: tb/gpio_evt_notify_test.sv
module gpio_evt_notify_test;
    localparam int DB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0, cfg_edge = '0, cfg_inv = '0, cfg_dbnc = '0;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       evt_notify;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_evt_notify uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_edge(cfg_edge),
        .cfg_invert(cfg_inv), .cfg_debounce(cfg_dbnc), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_notify(evt_notify)
    );

    // Reference model built from the requirements.
    logic [7:0] m_st, m_en, m_flt, m_prev;
    logic [7:0] ma, ms, mt, mc;
    int         m_cnt [8];

    always @(posedge clk) begin
        ma = pin_in ^ cfg_inv;
        ms = (cfg_dbnc & m_flt) | (~cfg_dbnc & ma);
        mt = (cfg_edge & ms & ~m_prev) | (~cfg_edge & ms);
        mc = (reg_wr && reg_addr) ? reg_wdata : 8'h00;
        m_prev <= ms;
        if (!rst_n) begin
            m_st  <= '0;
            m_en  <= '0;
            m_flt <= ma;
            for (int i = 0; i < 8; i++) m_cnt[i] <= 0;
        end else begin
            m_st <= (m_st & ~mc) | mt;
            if (reg_wr && !reg_addr) m_en <= reg_wdata;
            for (int i = 0; i < 8; i++) begin
                if (ma[i] == m_flt[i]) m_cnt[i] <= 0;
                else if (m_cnt[i] == DB - 1) begin
                    m_flt[i] <= ma[i];
                    m_cnt[i] <= 0;
                end else m_cnt[i] <= m_cnt[i] + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read a register through the port, masked.
    task automatic rd(input logic a, input logic [7:0] mask, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(req, reg_rdata & mask, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        pin_in[0] = 1'b1; cfg_edge[0] = 1'b1;        // active during reset (R9)
        step(4);
        rst_n = 1'b1;
        rd(1, 8'hFF, 8'h00, "R1 pending");
        rd(0, 8'hFF, 8'h00, "R1 enable");
        chk("R1 notify", {7'b0, evt_notify}, 8'h00);
        step(3);
        rd(1, 8'h01, 8'h00, "R9 no edge at reset");
        // R4: edge mode
        pin_in[0] = 1'b0; step(2);
        rd(1, 8'h01, 8'h00, "R4 low");
        pin_in[0] = 1'b1; step(1);
        rd(1, 8'h01, 8'h01, "R4 rise sets");
        wr(1, 8'h01);
        step(1);
        rd(1, 8'h01, 8'h00, "R4 held level no reset");
        // R7: rise and clear together
        pin_in[0] = 1'b0; step(1);
        pin_in[0] = 1'b1; wr(1, 8'h01);
        rd(1, 8'h01, 8'h01, "R7 trigger wins");
        wr(1, 8'h01);
        rd(1, 8'h01, 8'h00, "R6 clear edge bit");
        // R3: level mode on pin 1
        pin_in[1] = 1'b1; step(1);
        rd(1, 8'h02, 8'h02, "R3 level sets");
        wr(1, 8'h02);
        rd(1, 8'h02, 8'h02, "R3 level resets after clear");
        pin_in[1] = 1'b0; step(1);
        rd(1, 8'h02, 8'h02, "R10 sticky");
        wr(1, 8'hFD);
        rd(1, 8'h02, 8'h02, "R6 write zero keeps");
        wr(1, 8'h02);
        rd(1, 8'h02, 8'h00, "R6 write one clears");
        // R8: enable gating
        pin_in[1] = 1'b1; step(1); pin_in[1] = 1'b0;
        wr(0, 8'h20);
        rd(0, 8'hFF, 8'h20, "R8 enable readback");
        chk("R8 notify masked", {7'b0, evt_notify}, 8'h00);
        wr(0, 8'h22);
        #1 chk("R8 notify on", {7'b0, evt_notify}, 8'h01);
        wr(1, 8'h02);
        #1 chk("R8 notify off after clear", {7'b0, evt_notify}, 8'h00);
        wr(0, 8'h00);
        // R2: inverted pin 2
        pin_in[2] = 1'b1; cfg_inv[2] = 1'b1; step(2);
        rd(1, 8'h04, 8'h00, "R2 high inactive");
        pin_in[2] = 1'b0; step(1);
        rd(1, 8'h04, 8'h04, "R2 low active");
        pin_in[2] = 1'b1; wr(1, 8'h04);
        rd(1, 8'h04, 8'h00, "R2 cleared");
        // R5: debounce on pin 3
        cfg_dbnc[3] = 1'b1; step(2);
        pin_in[3] = 1'b1; step(DB - 1); pin_in[3] = 1'b0; step(3);
        rd(1, 8'h08, 8'h00, "R5 short run ignored");
        pin_in[3] = 1'b1; step(DB);
        rd(1, 8'h08, 8'h00, "R5 not yet after 16");
        step(1);
        rd(1, 8'h08, 8'h08, "R5 set after filter");
        pin_in[3] = 1'b0; step(DB + 4);
        wr(1, 8'h08);
        rd(1, 8'h08, 8'h00, "R5 cleared");
        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) begin
                cfg_edge = 8'($urandom); cfg_inv = 8'($urandom); cfg_dbnc = 8'($urandom);
            end
            for (int i = 0; i < 8; i++)
                if ($urandom_range(0, 24) == 0) pin_in[i] = ~pin_in[i];
            reg_wr    = ($urandom_range(0, 3) == 0);
            reg_addr  = 1'($urandom);
            reg_wdata = 8'($urandom);
            #1;
            chk(reg_addr ? "R3 R6 R10 random pending" : "R8 random enable",
                reg_rdata, reg_addr ? m_st : m_en);
            chk("R8 random notify", {7'b0, evt_notify}, {7'b0, |(m_st & m_en)});
            @(negedge clk);
        end
        reg_wr = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule